// File: doc/BRIEF.md
# Token Ring Station Simulator

This block models a ring of stations that pass tokens around in one direction. Each station has a request input, usually wired to a switch, and a lamp output. When a station holds a token and its request is high, it keeps the token for a long transmit slot and lights its lamp. When a station holds a token and its request is low, it hands the token on after one short slot. Time advances in ticks. A divider inside the block makes one tick every `TICK_DIV` clock cycles.

A one-cycle insert pulse puts a token at station 0. Pulsing insert again while tokens are already circulating adds more tokens. A one-cycle clear pulse empties the ring and restarts the tick divider. Each station stores its occupancy as one bit. If a token arrives at a station that is already occupied, the two tokens merge into one, so the number of tokens in the ring can only go down between inserts.

Top module: `token_ring_sim`

## Requirements
- R1: `led_o[i]` is high exactly when station i holds a token and `req_i[i]` is high, in the same cycle.
- R2: After a clear cycle the divider count is zero. A tick occurs in every cycle whose count equals `TICK_DIV-1`, so one tick happens every `TICK_DIV` cycles.
- R3: A station whose request stays high keeps a token for exactly `HOLD_TX` ticks after the arrival, then passes it on.
- R4: A station whose request is low passes a token on at the first tick after the token arrives (`HOLD_FAST` = 1 tick).
- R5: An insert pulse in any cycle without clear places a token at station 0 in the next cycle and restarts that station's hold count.
- R6: A clear pulse empties every station in the next cycle. When clear and insert are high together, clear wins and the ring is left empty.
- R7: A token that arrives at an occupied station merges with the token already there. One token remains, and its hold count restarts from the arrival.
- R8: Without an insert, the number of tokens in the ring never increases from one cycle to the next.
- R9: While reset is asserted, and after it is released, the ring holds no token.
- R10: A token leaving station i arrives at station (i+1) mod `N_STN`, so a token leaving station 7 arrives at station 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| req_i | input | N_STN | Request per station; high means the station wants to transmit |
| insert_i | input | 1 | One-cycle pulse that injects a token at station 0 |
| clear_i | input | 1 | One-cycle pulse that removes all tokens and restarts the divider |
| led_o | output | N_STN | Lamp per station; high while that station is transmitting |

## Verification
Errors in occupancy or in the hold counters show up on the lamps when the requests are high. A lost or duplicated token changes how many lamps are lit once all requests are set. A hold counter that is off by one moves a lamp one tick early or late, which is at most `TICK_DIV` cycles. A wrong divider phase shifts every token handoff after the next clear. The bench therefore compares the lamps against a reference model on every cycle, so a divergence is reported within one tick of its cause.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam int unsigned TR_STATIONS  = 8;
  localparam int unsigned TR_HOLD_TX   = 8;
  localparam int unsigned TR_HOLD_FAST = 1;
  localparam int unsigned TR_TICK_DIV  = 4;

  // per-station next-state bundle
  typedef struct packed {
    logic occ;
    logic reload;
    logic advance;
  } stn_ctl_t;
endpackage

// File: rtl/tr_reset_sync.sv
module tr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tr_tick_div.sv
module tr_tick_div #(
  parameter int unsigned TICK_DIV = tr_pkg::TR_TICK_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = (cnt_q == LAST);
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R2

  generate
    if (TICK_DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/tr_station.sv
module tr_station #(
  parameter int unsigned HOLD_TX   = tr_pkg::TR_HOLD_TX,
  parameter int unsigned HOLD_FAST = tr_pkg::TR_HOLD_FAST
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic inject,
  input  logic req,
  input  logic tok_in,
  output logic tok_out,
  output logic occ
);
  import tr_pkg::*;

  localparam int unsigned CNT_W = $clog2(HOLD_TX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             occ_q, occ_d;
  logic [CNT_W-1:0] limit;
  logic             slot_done;
  logic             arrive;
  stn_ctl_t         ctl;

  always_comb begin
    limit     = req ? CNT_W'(HOLD_TX) : CNT_W'(HOLD_FAST);
    slot_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
    tok_out   = occ_q & tick & slot_done;
    arrive    = tok_in | inject;

    ctl.occ     = occ_q;
    ctl.reload  = 1'b0;
    ctl.advance = 1'b0;
    if (clear) begin
      ctl.occ    = 1'b0;
      ctl.reload = 1'b1;
    end else if (arrive) begin
      ctl.occ    = 1'b1;          // merge: one token survives
      ctl.reload = 1'b1;
    end else if (tok_out) begin
      ctl.occ    = 1'b0;
      ctl.reload = 1'b1;
    end else if (occ_q && tick) begin
      ctl.advance = 1'b1;
    end

    occ_d = ctl.occ;
    if (ctl.reload)       cnt_d = '0;
    else if (ctl.advance) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      occ_q <= occ_d;
      cnt_q <= cnt_d;
    end
  end

  assign occ = occ_q;

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(HOLD_TX)); // R3
  AST_TX_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && req && tick && !slot_done && !arrive && !clear) |=> occ_q); // R3
  AST_FAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !req && tick && !arrive && !clear) |=> !occ_q); // R4
  AST_ARRIVE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !clear) |=> (occ_q && cnt_q == '0)); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !occ_q); // R6
endmodule

// File: rtl/token_ring_sim.sv
module token_ring_sim #(
  parameter int unsigned N_STN     = tr_pkg::TR_STATIONS,
  parameter int unsigned HOLD_TX   = tr_pkg::TR_HOLD_TX,
  parameter int unsigned HOLD_FAST = tr_pkg::TR_HOLD_FAST,
  parameter int unsigned TICK_DIV  = tr_pkg::TR_TICK_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_STN-1:0] req_i,
  input  logic             insert_i,
  input  logic             clear_i,
  output logic [N_STN-1:0] led_o
);
  logic             rst_q_n;
  logic             tick;
  logic [N_STN-1:0] occ;
  logic [N_STN-1:0] dep;
  logic [N_STN-1:0] inj;

  tr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  tr_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (clear_i),
    .tick    (tick)
  );

  assign inj = {{(N_STN-1){1'b0}}, insert_i};

  generate
    for (genvar i = 0; i < N_STN; i++) begin : g_stn
      localparam int unsigned PREV = (i + N_STN - 1) % N_STN;
      tr_station #(.HOLD_TX(HOLD_TX), .HOLD_FAST(HOLD_FAST)) u_stn (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .tick    (tick),
        .clear   (clear_i),
        .inject  (inj[i]),
        .req     (req_i[i]),
        .tok_in  (dep[PREV]),
        .tok_out (dep[i]),
        .occ     (occ[i])
      );
    end
  endgenerate

  assign led_o = occ & req_i;

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (insert_i && !clear_i) |=> occ[0]); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (insert_i && clear_i) |=> (occ == '0)); // R6
  AST_NO_TOKEN_GROWTH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!insert_i && !clear_i) |=> ($countones(occ) <= $countones($past(occ)))); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_q_n |-> (occ == '0)); // R9
  AST_WRAP_ARRIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dep[N_STN-1] && !clear_i) |=> occ[0]); // R10
endmodule

// File: tb/sim_token_ring_sim.sv
module sim_token_ring_sim;
  localparam int N   = 8;
  localparam int HTX = 8;
  localparam int HFS = 1;
  localparam int DIV = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         ins, clr;
  logic [N-1:0] led;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int m_div;
  bit m_occ [N];
  int m_cnt [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  token_ring_sim #(.N_STN(N), .HOLD_TX(HTX), .HOLD_FAST(HFS), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .insert_i(ins), .clear_i(clr), .led_o(led)
  );

  function automatic int lim_of(bit r);
    return r ? HTX : HFS;
  endfunction

  function automatic logic [N-1:0] exp_led();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_occ[i] & req[i];
    return v;
  endfunction

  task automatic model_update();
    bit tk;
    bit dep [N];
    tk = (m_div == DIV-1);
    for (int i = 0; i < N; i++)
      dep[i] = m_occ[i] && tk && (m_cnt[i] + 1 >= lim_of(req[i]));
    for (int i = 0; i < N; i++) begin
      bit arr;
      arr = dep[(i+N-1)%N] || (i == 0 && ins);
      if (clr)                  begin m_occ[i] = 0; m_cnt[i] = 0; end
      else if (arr)             begin m_occ[i] = 1; m_cnt[i] = 0; end
      else if (dep[i])          begin m_occ[i] = 0; m_cnt[i] = 0; end
      else if (m_occ[i] && tk)  m_cnt[i]++;
    end
    m_div = (clr || tk) ? 0 : m_div + 1;
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: reference steps at the edge, lamps compared at the falling edge
  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(tag, led, exp_led());
    ins = 1'b0;
    clr = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    int seed;
    seed  = $urandom(32'd4242);
    rst_n = 1'b0;
    req   = '1;
    ins   = 1'b0;
    clr   = 1'b0;
    m_div = 0;
    for (int i = 0; i < N; i++) begin m_occ[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R9 empty in reset", led, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 empty after reset", led, '0);

    // sync model via clear
    clr = 1'b1; step("R2 clear sync");

    // R5: insert lands at station 0, R3: long holds
    ins = 1'b1; step("R5 insert");
    chk("R5 station0 lit", led, 8'h01);
    run(HTX*DIV + 2, "R3 hold");
    chk("R3 moved to station1", led, 8'h02);
    run(HTX*DIV*8, "R10 wrap with holds");

    // R4: fast passing, R10 wrap through 7->0
    req = 8'h00;
    run(DIV*20, "R4 fast pass");
    req = 8'h80;
    run(DIV*10, "R10 watch 7");
    req = 8'h01;
    run(DIV*10, "R10 watch 0");

    // R6: clear with insert
    req = '1;
    clr = 1'b1; ins = 1'b1; step("R6 clear wins");
    chk("R6 ring empty", led, '0);
    run(DIV*4, "R6 stays empty");

    // R7/R8: merge at a holding station
    req = 8'h08;
    clr = 1'b1; step("R7 prep");
    ins = 1'b1; step("R7 first token");
    run(DIV*4, "R7 first reaches 3");
    ins = 1'b1; step("R7 second token");
    run(DIV*4, "R7 merge");
    req = '1;
    step("R8 count");
    checks++;
    if ($countones(led) != 1) begin
      fails++;
      $display("FAIL R7 token count actual=%0d expected=1", $countones(led));
    end
    run(HTX*DIV*3, "R7 after merge");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 7) == 0) req[$urandom_range(0, N-1)] ^= 1'b1;
      ins = ($urandom_range(0, 39) == 0);
      clr = ($urandom_range(0, 299) == 0);
      step("R1 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule